// File: doc/BRIEF.md
# Conditional Skip Decision Unit

This block decides, one instruction slot at a time, whether a small 8-bit accumulator core should suppress the instruction that follows the current one. The core hands it a decoded test code together with the operands that test needs: the accumulator, a memory operand, a pointer register, a 4-bit immediate, a bit index with a source select, the carry flag and a general register value. Each test follows "do the next instruction if the condition holds". When the condition fails, the unit raises a skip request. The core then uses that request to squash the following instruction.

The decrement test also returns the register value minus one, with a write-enable, so that the core can write it back. A return-and-skip code always asks for a skip. All results are registered. They appear in the slot after the test code is presented and last for exactly that one slot. The asynchronous active-low reset is synchronised internally before it releases the registers.

Top module: `skip_decide_unit`

## Requirements
- R1: Greater-than test (code 1): the 8-bit comparison of `acc` against `mem_opnd` is unsigned. A skip is requested when `acc` is not strictly greater, so equal operands also skip.
- R2: Pointer-nibble test (code 2): a skip is requested when `b_ptr[3:0]` equals `imm4`. The upper bits of `b_ptr` have no effect.
- R3: Decrement test (code 3): `wb_en` rises and `wb_data` carries `reg_val` minus one, modulo 256. The value 0 therefore gives 255. A skip is requested only when that result is zero.
- R4: Bit test (code 4): `bit_idx` (0 to 7) selects a bit of `acc` when `bit_src` is 0, or of `mem_opnd` when `bit_src` is 1. A skip is requested when the selected bit is 0.
- R5: Carry-set test (code 5) requests a skip when `carry` is 0. Carry-clear test (code 6) requests a skip when `carry` is 1.
- R6: Return-and-skip (code 7) always requests a skip.
- R7: Results are registered. A code sampled with `op_valid` high on one rising edge drives `skip_req`, `wb_en` and `wb_data` after that edge, for exactly one cycle. The results of back-to-back codes follow one another cycle by cycle.
- R8: When `op_valid` is low, or when the code is 0 (no test), neither a skip nor a writeback is requested in the next cycle. `wb_en` stays low for every code other than 3.
- R9: While reset is asserted, and until the synchronised reset releases, `skip_req` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Test code valid this slot |
| op_code | input | 3 | Test code (0 none, 1 greater, 2 nibble, 3 decrement, 4 bit, 5 carry set, 6 carry clear, 7 return-skip) |
| acc | input | 8 | Accumulator |
| mem_opnd | input | 8 | Memory operand |
| b_ptr | input | 8 | Pointer register |
| imm4 | input | 4 | Immediate for nibble test |
| bit_idx | input | 3 | Bit index for bit test |
| bit_src | input | 1 | Bit test source: 0 accumulator, 1 memory |
| carry | input | 1 | Carry flag |
| reg_val | input | 8 | Register operand of decrement test |
| skip_req | output | 1 | Skip the next instruction |
| wb_en | output | 1 | Register writeback valid |
| wb_data | output | 8 | Decremented register value |

## Verification
The embedded properties watch the slot-by-slot rules on every cycle. They check that the greater-than and carry outcomes follow the sampled operands, that return-and-skip always skips, and that a writeback carries the previous register value less one. They also check that a writeback's zero result matches the skip, and that an idle slot produces neither output. The bench scenarios are needed for the operand corners: unsigned ordering near 0x80 and 200, equal operands, pointer bits above the nibble, every bit index from both sources, and decrement wrap from 0. They also cover back-to-back skip requests and the reset state.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    TST_NONE  = 3'd0,
    TST_AGT   = 3'd1,
    TST_BNIB  = 3'd2,
    TST_DECZ  = 3'd3,
    TST_BIT   = 3'd4,
    TST_CSET  = 3'd5,
    TST_CCLR  = 3'd6,
    TST_RSKIP = 3'd7
  } tst_op_e;
endpackage

// File: rtl/skip_rst_sync.sv
module skip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/skip_dec_path.sv
module skip_dec_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] reg_in,
  output logic [DATA_W-1:0] dec_val,
  output logic              dec_zero
);
  always_comb begin
    dec_val  = reg_in - DATA_W'(1);
    dec_zero = (dec_val == '0);
  end
endmodule

// File: rtl/skip_test_eval.sv
module skip_test_eval
  import skip_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  tst_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem_opnd,
  input  logic [DATA_W-1:0] b_ptr,
  input  logic [NIB_W-1:0]  imm,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_src,
  input  logic              carry,
  input  logic              dec_zero,
  output logic              skip
);
  logic [NIB_W-1:0]  nib_diff;
  logic              nib_ne;
  logic [DATA_W-1:0] bit_word;
  logic              sel_bit;
  logic              acc_gt;

  // bitwise difference of pointer nibble and immediate
  for (genvar g = 0; g < NIB_W; g++) begin : g_nib
    assign nib_diff[g] = b_ptr[g] ^ imm[g];
  end

  always_comb begin
    nib_ne   = |nib_diff;
    bit_word = bit_src ? mem_opnd : acc;
    sel_bit  = bit_word[bit_idx];
    acc_gt   = (acc > mem_opnd);
  end

  // skip = condition for executing next instruction is false
  always_comb begin
    unique case (op)
      TST_AGT:   skip = !acc_gt;
      TST_BNIB:  skip = !nib_ne;
      TST_DECZ:  skip = dec_zero;
      TST_BIT:   skip = !sel_bit;
      TST_CSET:  skip = !carry;
      TST_CCLR:  skip = carry;
      TST_RSKIP: skip = 1'b1;
      default:   skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_out_stage.sv
module skip_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              skip_d,
  input  logic              wb_en_d,
  input  logic [DATA_W-1:0] wb_data_d,
  output logic              skip_q,
  output logic              wb_en_q,
  output logic [DATA_W-1:0] wb_data_q
);
  logic              skip_nxt;
  logic              wb_en_nxt;
  logic [DATA_W-1:0] wb_data_nxt;
  logic              data_ce;

  always_comb begin
    skip_nxt    = skip_d;
    wb_en_nxt   = wb_en_d;
    data_ce     = wb_en_d;
    wb_data_nxt = wb_data_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      skip_q  <= 1'b0;
      wb_en_q <= 1'b0;
    end else begin
      skip_q  <= skip_nxt;
      wb_en_q <= wb_en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     wb_data_q <= '0;
    else if (data_ce) wb_data_q <= wb_data_nxt;
  end

  // a skip request lasts one slot unless a new request is presented
  p_skip_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !skip_d |=> !skip_q);

  // writeback data loads only on a writeback
  p_wb_hold_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wb_en_d |=> $stable(wb_data_q));
endmodule

// File: rtl/skip_decide_unit.sv
module skip_decide_unit
  import skip_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem_opnd,
  input  logic [DATA_W-1:0] b_ptr,
  input  logic [NIB_W-1:0]  imm4,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_src,
  input  logic              carry,
  input  logic [DATA_W-1:0] reg_val,
  output logic              skip_req,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data
);
  logic              rst_s_n;
  tst_op_e           op_act;
  logic [DATA_W-1:0] dec_val;
  logic              dec_zero;
  logic              skip_d;
  logic              wb_en_d;

  skip_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  always_comb begin
    op_act  = op_valid ? tst_op_e'(op_code) : TST_NONE;
    wb_en_d = (op_act == TST_DECZ);
  end

  skip_dec_path #(.DATA_W(DATA_W)) u_dec (
    .reg_in   (reg_val),
    .dec_val  (dec_val),
    .dec_zero (dec_zero)
  );

  skip_test_eval #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_eval (
    .op       (op_act),
    .acc      (acc),
    .mem_opnd (mem_opnd),
    .b_ptr    (b_ptr),
    .imm      (imm4),
    .bit_idx  (bit_idx),
    .bit_src  (bit_src),
    .carry    (carry),
    .dec_zero (dec_zero),
    .skip     (skip_d)
  );

  skip_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_s_n   (rst_s_n),
    .skip_d    (skip_d),
    .wb_en_d   (wb_en_d),
    .wb_data_d (dec_val),
    .skip_q    (skip_req),
    .wb_en_q   (wb_en),
    .wb_data_q (wb_data)
  );

  p_gt_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && op_code == 3'd1) |=> (skip_req == ($past(acc) <= $past(mem_opnd))));

  p_dec_wb_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && op_code == 3'd3) |=> (wb_en && wb_data == DATA_W'($past(reg_val) - 1'b1)));

  p_dec_zero_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    wb_en |-> (skip_req == (wb_data == '0)));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && op_code == 3'd5) |=> (skip_req == !$past(carry)));

  p_rskip_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && op_code == 3'd7) |=> skip_req);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!op_valid || op_code == 3'd0) |=> (!skip_req && !wb_en));

  p_wb_only_dec_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && op_code != 3'd3) |=> !wb_en);

  p_reset_r9: assert property (@(posedge clk)
    !rst_s_n |-> (!skip_req && !wb_en));
endmodule

// File: tb/tb_skip_decide_unit.sv
module tb_skip_decide_unit;
  typedef struct {
    logic       skip;
    logic       wben;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_code;
  logic [7:0] acc, mem_opnd, b_ptr, reg_val;
  logic [3:0] imm4;
  logic [2:0] bit_idx;
  logic       bit_src, carry;
  logic       skip_req, wb_en;
  logic [7:0] wb_data;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  skip_decide_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc(acc), .mem_opnd(mem_opnd), .b_ptr(b_ptr), .imm4(imm4),
    .bit_idx(bit_idx), .bit_src(bit_src), .carry(carry), .reg_val(reg_val),
    .skip_req(skip_req), .wb_en(wb_en), .wb_data(wb_data)
  );

  // expected results computed from the requirements
  function automatic exp_t model(input logic v, input logic [2:0] c,
      input logic [7:0] a, input logic [7:0] m, input logic [7:0] b,
      input logic [3:0] im, input logic [2:0] ix, input logic src,
      input logic cy, input logic [7:0] rv, input string tag);
    exp_t e;
    logic [7:0] w;
    e.skip = 1'b0; e.wben = 1'b0; e.data = 8'h00; e.tag = tag;
    if (v) begin
      case (c)
        3'd1: e.skip = !(a > m);                          // R1
        3'd2: e.skip = (b[3:0] == im);                     // R2
        3'd3: begin                                        // R3
          e.data = rv - 8'd1; e.wben = 1'b1; e.skip = (e.data == 8'd0);
        end
        3'd4: begin w = src ? m : a; e.skip = !w[ix]; end  // R4
        3'd5: e.skip = !cy;                                // R5
        3'd6: e.skip = cy;                                 // R5
        3'd7: e.skip = 1'b1;                               // R6
        default: ;                                         // R8
      endcase
    end
    return e;
  endfunction

  task automatic drive(input logic v, input logic [2:0] c, input logic [7:0] a,
      input logic [7:0] m, input logic [7:0] b, input logic [3:0] im,
      input logic [2:0] ix, input logic src, input logic cy,
      input logic [7:0] rv, input string tag);
    @(negedge clk);
    op_valid = v; op_code = c; acc = a; mem_opnd = m; b_ptr = b; imm4 = im;
    bit_idx = ix; bit_src = src; carry = cy; reg_val = rv;
    sb_q.push_back(model(v, c, a, m, b, im, ix, src, cy, rv, tag));
  endtask

  // monitor: the item pushed before an edge is compared just after it (R7)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (skip_req !== e.skip || wb_en !== e.wben ||
            (e.wben && wb_data !== e.data)) begin
          n_bad++;
          $display("FAIL %s: skip/wb_en/wb_data = %b/%b/%02h expected %b/%b/%02h",
                   e.tag, skip_req, wb_en, wb_data, e.skip, e.wben, e.data);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; acc = 8'h00; mem_opnd = 8'h00;
    b_ptr = 8'h00; imm4 = 4'h0; bit_idx = 3'd0; bit_src = 1'b0; carry = 1'b0;
    reg_val = 8'h00;
    repeat (3) @(negedge clk);
    n_vec++;
    if (skip_req !== 1'b0 || wb_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: skip/wb_en = %b/%b expected 0/0", skip_req, wb_en);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_vec++;
    if (skip_req !== 1'b0 || wb_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 after release: skip/wb_en = %b/%b expected 0/0", skip_req, wb_en);
    end

    // R1 unsigned greater-than
    drive(1, 3'd1, 8'd5,   8'd3,   0, 0, 0, 0, 0, 0, "R1 5>3");
    drive(1, 3'd1, 8'd3,   8'd3,   0, 0, 0, 0, 0, 0, "R1 equal");
    drive(1, 3'd1, 8'd200, 8'd2,   0, 0, 0, 0, 0, 0, "R1 200>2");
    drive(1, 3'd1, 8'd2,   8'd200, 0, 0, 0, 0, 0, 0, "R1 2<200");
    drive(1, 3'd1, 8'h80,  8'h7F,  0, 0, 0, 0, 0, 0, "R1 80>7F");
    // R2 nibble compare
    drive(1, 3'd2, 0, 0, 8'h35, 4'h5, 0, 0, 0, 0, "R2 equal");
    drive(1, 3'd2, 0, 0, 8'h35, 4'h6, 0, 0, 0, 0, "R2 differ");
    drive(1, 3'd2, 0, 0, 8'hF5, 4'h5, 0, 0, 0, 0, "R2 upper ignored");
    // R3 decrement
    drive(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 8'd1,  "R3 to zero");
    drive(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 8'd0,  "R3 wrap");
    drive(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 8'h80, "R3 mid");
    drive(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 8'd2,  "R3 to one");
    // R4 bit test, every index from both sources
    for (int i = 0; i < 8; i++) begin
      drive(1, 3'd4, 8'hA5, 8'h5A, 0, 0, 3'(i), 1'b0, 0, 0, "R4 acc");
      drive(1, 3'd4, 8'hA5, 8'h5A, 0, 0, 3'(i), 1'b1, 0, 0, "R4 mem");
    end
    // R5 carry tests
    drive(1, 3'd5, 0, 0, 0, 0, 0, 0, 1'b1, 0, "R5 cset c=1");
    drive(1, 3'd5, 0, 0, 0, 0, 0, 0, 1'b0, 0, "R5 cset c=0");
    drive(1, 3'd6, 0, 0, 0, 0, 0, 0, 1'b1, 0, "R5 cclr c=1");
    drive(1, 3'd6, 0, 0, 0, 0, 0, 0, 1'b0, 0, "R5 cclr c=0");
    // R6 and R7: back-to-back skips then clear
    drive(1, 3'd7, 0, 0, 0, 0, 0, 0, 0, 0, "R6 rskip a");
    drive(1, 3'd7, 0, 0, 0, 0, 0, 0, 0, 0, "R6 rskip b");
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 clear");
    // R8 idle and no-test code
    drive(0, 3'd7, 0, 0, 0, 0, 0, 0, 1'b1, 8'd1, "R8 invalid rskip");
    drive(0, 3'd3, 0, 0, 0, 0, 0, 0, 0, 8'd1, "R8 invalid dec");
    drive(1, 3'd0, 8'd0, 8'd9, 8'h05, 4'h5, 0, 0, 0, 8'd1, "R8 none");
    drive(1, 3'd1, 8'd1, 8'd1, 0, 0, 0, 0, 0, 8'd1, "R8 no wb on gt");
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 tail");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule